// File: doc/BRIEF.md
# Two-Wire Serial Memory Target Front End

This block is the bit-level front end of a small serial memory that answers on a two-wire bus. It oversamples the clock and data lines with the system clock and cleans them with a short stability filter. It finds start, repeated-start and stop conditions and shifts bytes in and out, most significant bit first. It compares the address byte against two device-type codes and three strap inputs, and it answers with an acknowledge bit. Data goes onto the bus only through an active-low output enable.

Behind it sits a memory controller. The front end hands that controller each received byte, one-cycle start and stop strobes, the read/write flag and a flag that tells the main array from the identification page. The controller answers with an accept decision for each written byte, and it supplies the next read byte when asked. While the controller reports an internal write cycle, every acknowledge is withheld. A bus master can therefore poll for completion by sending address bytes until one is acknowledged.

Top module: `twi_mem_target`

## Requirements
- R1: An SDA fall while SCL is high gives a one-cycle `start_pulse`. An SDA rise while SCL is high gives a one-cycle `stop_pulse`. Neither of these is ever taken as a data bit.
- R2: Each line passes through a two-flop synchronizer and then a filter that accepts a new level only after three equal samples. An SDA pulse of two system clocks while SCL is high causes no strobe.
- R3: The address byte is bits [7:4] device type, bits [3:1] chip select and bit [0] direction. Type 4'b1010 (main array) or 4'b1011 (identification page), together with a chip select equal to `strap_sel`, is acknowledged by pulling SDA low in the ninth clock and sets `addr_hit`.
- R4: On a wrong type or a wrong chip select there is no acknowledge. The block then ignores the bus until the next start: later bytes get no acknowledge and no `rx_valid`.
- R5: While `wr_busy` is 1, no acknowledge is given, not even to a matching address.
- R6: After a match, `rw_flag` holds the direction bit (1 = read) and `id_sel` is 1 exactly when the type was 4'b1011.
- R7: In write direction, each data byte is captured MSB first on the SCL rising edges and presented on `rx_data` with a one-cycle `rx_valid`.
- R8: A written data byte is acknowledged only if `rx_ack` is 1 at the falling SCL edge after the eighth bit. A byte that is not acknowledged ends the transfer: later bytes are neither acknowledged nor presented.
- R9: In read direction, `tx_data` is sent MSB first. Each bit changes only after an SCL falling edge. SDA is either released or pulled low.
- R10: In read direction, a master bit of 0 in the ninth clock raises `tx_req` and continues with the next byte. A master bit of 1 releases SDA until the next start or stop.
- R11: A start seen in the middle of a byte drops that byte and resets the bit count, so the next address byte is decoded normally.
- R12: After reset, `sda_oe`, `addr_hit` and all strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| strap_sel | input | 3 | Chip-select straps |
| wr_busy | input | 1 | Internal write cycle in progress |
| start_pulse | output | 1 | Start or repeated start seen |
| stop_pulse | output | 1 | Stop seen |
| addr_hit | output | 1 | Address matched and acknowledged |
| rw_flag | output | 1 | Direction of the current transfer, 1 = read |
| id_sel | output | 1 | Identification page selected |
| rx_data | output | 8 | Last received data byte |
| rx_valid | output | 1 | `rx_data` updated this cycle |
| rx_ack | input | 1 | Controller accepts the current written byte |
| tx_data | input | 8 | Next byte to send |
| tx_req | output | 1 | Controller must present the next read byte |

## Verification
A line change at the pins reaches the filtered level about six system clocks later. Strobes and received bytes follow one clock after that. An SDA drive follows the SCL falling edge by about seven clocks. The bench works in quarter bus periods of eight clocks. It drives data in the middle of the SCL low phase and samples the bus one quarter after SCL rises, so each result is checked after it has settled and before the next edge. Strobes and `rx_valid` pulses are counted every clock, and the counts are compared at the end of each bus phase.

// File: rtl/twi_mem_target.sv
module twi_mem_target #(
  parameter logic [3:0] MAIN_TYPE = 4'b1010,
  parameter logic [3:0] IDPG_TYPE = 4'b1011,
  parameter int FILT_LEN = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] strap_sel,
  input  logic       wr_busy,
  output logic       start_pulse,
  output logic       stop_pulse,
  output logic       addr_hit,
  output logic       rw_flag,
  output logic       id_sel,
  output logic [7:0] rx_data,
  output logic       rx_valid,
  input  logic       rx_ack,
  input  logic [7:0] tx_data,
  output logic       tx_req
);
  typedef enum logic [2:0] {ST_IDLE, ST_ADDR, ST_WR, ST_RD, ST_WAIT} st_t;

  logic [1:0] scl_sy, sda_sy;
  logic [FILT_LEN-1:0] scl_h, sda_h;
  logic scl_f, sda_f, scl_q, sda_q;
  st_t st;
  logic [3:0] cnt;
  logic [7:0] sr;
  logic ack_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1;
      scl_h <= '1; sda_h <= '1;
      scl_f <= 1'b1; sda_f <= 1'b1;
      scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_h <= {scl_h[FILT_LEN-2:0], scl_sy[1]};
      sda_h <= {sda_h[FILT_LEN-2:0], sda_sy[1]};
      if (&scl_h) scl_f <= 1'b1; else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h) sda_f <= 1'b1; else if (~|sda_h) sda_f <= 1'b0;
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  wire scl_rise  = scl_f & ~scl_q;
  wire scl_fall  = ~scl_f & scl_q;
  wire start_det = scl_f & scl_q & sda_q & ~sda_f;
  wire stop_det  = scl_f & scl_q & ~sda_q & sda_f;
  wire busy_st   = (st == ST_ADDR) || (st == ST_WR) || (st == ST_RD);
  wire type_ok   = (sr[6:3] == MAIN_TYPE) || (sr[6:3] == IDPG_TYPE);
  wire hit_now   = type_ok && (sr[2:0] == strap_sel) && !wr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; cnt <= '0; sr <= '0; ack_q <= 1'b0;
      sda_oe <= 1'b0; start_pulse <= 1'b0; stop_pulse <= 1'b0;
      addr_hit <= 1'b0; rw_flag <= 1'b0; id_sel <= 1'b0;
      rx_data <= '0; rx_valid <= 1'b0; tx_req <= 1'b0;
    end else begin
      start_pulse <= 1'b0;
      stop_pulse  <= 1'b0;
      rx_valid    <= 1'b0;
      tx_req      <= 1'b0;
      if (start_det) begin
        st <= ST_ADDR; cnt <= '0; sda_oe <= 1'b0; addr_hit <= 1'b0;
        start_pulse <= 1'b1;
      end else if (stop_det) begin
        st <= ST_IDLE; cnt <= '0; sda_oe <= 1'b0; addr_hit <= 1'b0;
        stop_pulse <= 1'b1;
      end else if (scl_rise && busy_st) begin
        if (cnt != 4'd9) cnt <= cnt + 4'd1;
        if (cnt < 4'd8 && st != ST_RD) sr <= {sr[6:0], sda_f};
        if (cnt == 4'd7 && st == ST_ADDR) begin
          if (hit_now) begin
            addr_hit <= 1'b1;
            rw_flag  <= sda_f;
            id_sel   <= (sr[6:3] == IDPG_TYPE);
            tx_req   <= sda_f;
          end else begin
            st <= ST_IDLE;
          end
        end
        if (cnt == 4'd7 && st == ST_WR) begin
          rx_data  <= {sr[6:0], sda_f};
          rx_valid <= 1'b1;
        end
        if (cnt == 4'd8 && st == ST_RD) begin
          ack_q  <= ~sda_f;
          tx_req <= ~sda_f;
        end
      end else if (scl_fall && busy_st) begin
        if (cnt == 4'd8) begin
          case (st)
            ST_ADDR: sda_oe <= 1'b1;
            ST_WR: begin
              sda_oe <= rx_ack & ~wr_busy;
              ack_q  <= rx_ack & ~wr_busy;
            end
            default: sda_oe <= 1'b0;
          endcase
        end else if (cnt == 4'd9) begin
          cnt <= '0;
          case (st)
            ST_ADDR: begin
              if (rw_flag) begin
                st <= ST_RD; sr <= tx_data; sda_oe <= ~tx_data[7];
              end else begin
                st <= ST_WR; sda_oe <= 1'b0;
              end
            end
            ST_WR: begin
              sda_oe <= 1'b0;
              if (!ack_q) st <= ST_WAIT;
            end
            default: begin
              if (ack_q) begin
                sr <= tx_data; sda_oe <= ~tx_data[7];
              end else begin
                st <= ST_WAIT; sda_oe <= 1'b0;
              end
            end
          endcase
        end else if (st == ST_RD && cnt != 4'd0) begin
          sda_oe <= ~sr[6];
          sr <= {sr[6:0], 1'b0};
        end
      end
    end
  end

  a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_pulse && stop_pulse));
  a_r9_drive_while_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_f);
  a_r5_no_hit_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_hit) |-> !$past(wr_busy));
  a_r7_rx_only_in_write: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (addr_hit && !rw_flag));
  a_r4_quiet_released: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE || st == ST_WAIT) |-> !sda_oe);
  a_r3_drive_only_addressed: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> addr_hit);
endmodule

// File: tb/twi_mem_target_tb.sv
module twi_mem_target_tb_top;
  localparam int Q = 8;
  localparam logic [2:0] STRAP = 3'b101;
  // [10:7] type, [6:4] chip select, [3] rw, [2] busy, [1] expected ack, [0] expected id_sel
  localparam logic [10:0] VEC [8] = '{
    11'b1010_101_0_0_1_0,
    11'b1011_101_1_0_1_1,
    11'b1010_100_0_0_0_0,
    11'b1110_101_0_0_0_0,
    11'b1010_101_0_1_0_0,
    11'b1011_101_0_0_1_1,
    11'b1010_101_1_0_1_0,
    11'b1001_101_1_0_0_0
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic wr_busy = 1'b0, rx_ack = 1'b1;
  logic [7:0] tx_data = 8'h00;
  logic sda_oe, start_pulse, stop_pulse, addr_hit, rw_flag, id_sel, rx_valid, tx_req;
  logic [7:0] rx_data;
  wire sda_bus = sda_m & ~sda_oe;

  int checks = 0, errors = 0, cyc = 0;
  int n_start = 0, n_stop = 0, n_rx = 0, tx_k = 0, rd_total = 0;
  logic [7:0] rx_last = 8'h00;

  twi_mem_target dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .strap_sel(STRAP), .wr_busy(wr_busy), .start_pulse(start_pulse),
    .stop_pulse(stop_pulse), .addr_hit(addr_hit), .rw_flag(rw_flag), .id_sel(id_sel),
    .rx_data(rx_data), .rx_valid(rx_valid), .rx_ack(rx_ack), .tx_data(tx_data),
    .tx_req(tx_req)
  );

  always #2 clk = ~clk;

  function automatic logic [7:0] tx_pat(input int k);
    return 8'h5A ^ 8'(k * 37);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (start_pulse) n_start <= n_start + 1;
    if (stop_pulse) n_stop <= n_stop + 1;
    if (rx_valid) begin n_rx <= n_rx + 1; rx_last <= rx_data; end
    if (tx_req) begin tx_data <= tx_pat(tx_k); tx_k <= tx_k + 1; end
    if (cyc == 150000) begin
      checks = checks + 1; errors = errors + 1;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      errors = errors + 1;
      $display("FAIL %s: act %0h exp %0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b);
    wq(Q); sda_m = b; wq(Q); scl_m = 1'b1; wq(2*Q); scl_m = 1'b0;
  endtask

  task automatic bit_in(output logic b);
    wq(Q); sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0;
  endtask

  task automatic do_start();
    sda_m = 1'b1; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b0; wq(2*Q); scl_m = 1'b0;
  endtask

  task automatic do_stop();
    wq(Q); sda_m = 1'b0; wq(Q); scl_m = 1'b1; wq(2*Q); sda_m = 1'b1; wq(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic ack);
    logic b;
    for (int i = 7; i >= 0; i--) bit_out(d[i]);
    bit_in(b);
    ack = ~b;
  endtask

  task automatic read_byte(input logic mack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin bit_in(b); d[i] = b; end
    bit_out(~mack);
  endtask

  initial begin
    logic ack;
    logic [7:0] d;
    logic [10:0] v;
    int s0, r0;
    wq(5);
    chk(sda_oe == 1'b0 && addr_hit == 1'b0, "R12 reset outputs", {sda_oe, addr_hit}, 0);
    rst_n = 1'b1;
    wq(10);
    chk(n_start == 0 && n_stop == 0 && n_rx == 0, "R12 no strobes", n_start + n_stop + n_rx, 0);

    sda_m = 1'b0; wq(2); sda_m = 1'b1; wq(20);
    chk(n_start == 0 && n_stop == 0, "R2 glitch filtered", n_start + n_stop, 0);

    for (int i = 0; i < 8; i++) begin
      v = VEC[i];
      wr_busy = v[2];
      s0 = n_start;
      do_start();
      if (i == 0) chk(n_start == s0 + 1, "R1 start strobe", n_start, s0 + 1);
      send_byte({v[10:4], v[3]}, ack);
      chk(ack == v[1], v[2] ? "R5 busy no ack" : (v[1] ? "R3 match ack" : "R4 mismatch no ack"),
          ack, v[1]);
      if (ack) begin
        chk(rw_flag == v[3], "R6 rw flag", rw_flag, v[3]);
        chk(id_sel == v[0], "R6 id select", id_sel, v[0]);
        if (v[3]) begin
          read_byte(1'b0, d);
          chk(d == tx_pat(rd_total), "R9 read byte", d, tx_pat(rd_total));
          rd_total++;
        end
      end else begin
        r0 = n_rx;
        send_byte(8'h3C, ack);
        chk(!ack && n_rx == r0, "R4 ignored after mismatch", {ack, 8'(n_rx - r0)}, 0);
      end
      s0 = n_stop;
      do_stop();
      if (i == 0) chk(n_stop == s0 + 1, "R1 stop strobe", n_stop, s0 + 1);
      wr_busy = 1'b0;
    end

    rx_ack = 1'b1;
    do_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    r0 = n_rx;
    send_byte(8'hC3, ack);
    chk(ack && n_rx == r0 + 1 && rx_last == 8'hC3, "R7 first byte", rx_last, 8'hC3);
    send_byte(8'h1E, ack);
    chk(ack && n_rx == r0 + 2 && rx_last == 8'h1E, "R7 second byte", rx_last, 8'h1E);
    rx_ack = 1'b0;
    send_byte(8'h77, ack);
    chk(!ack && rx_last == 8'h77, "R8 refused byte", {ack, rx_last}, 9'h077);
    rx_ack = 1'b1;
    r0 = n_rx;
    send_byte(8'h99, ack);
    chk(!ack && n_rx == r0, "R8 ended after refusal", {ack, 8'(n_rx - r0)}, 0);
    do_stop();

    do_start();
    send_byte({4'b1010, STRAP, 1'b0}, ack);
    wr_busy = 1'b1;
    r0 = n_rx;
    send_byte(8'h42, ack);
    chk(!ack && n_rx == r0 + 1, "R5 busy withholds data ack", ack, 0);
    wr_busy = 1'b0;
    do_stop();

    do_start();
    bit_out(1'b1); bit_out(1'b0); bit_out(1'b1);
    s0 = n_start;
    do_start();
    chk(n_start == s0 + 1, "R11 repeated start", n_start, s0 + 1);
    send_byte({4'b1011, STRAP, 1'b0}, ack);
    chk(ack && id_sel, "R11 address after abort", {ack, id_sel}, 2'b11);
    do_stop();

    do_start();
    send_byte({4'b1010, STRAP, 1'b1}, ack);
    chk(ack, "R10 read address ack", ack, 1);
    for (int k = 0; k < 3; k++) begin
      read_byte(k != 2, d);
      chk(d == tx_pat(rd_total), "R10 sequential byte", d, tx_pat(rd_total));
      rd_total++;
    end
    wq(Q);
    chk(sda_oe == 1'b0 && sda_bus == 1'b1, "R10 released after nack", sda_oe, 0);
    chk(tx_k == rd_total, "R10 request count", tx_k, rd_total);
    do_stop();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule